// File: doc/BRIEF.md
# Command Response Outcome Tracker

This block follows each command that an SD/MMC host puts on its command line and records how that command ended. Neighbouring logic supplies single-cycle pulses. One pulse marks a command being issued, and it carries a flag that says whether a reply is awaited. Another pulse marks the end of the command's transmission. Two more mark the start and the end of a reply, with a CRC verdict that is valid at the end of the reply. From these pulses the block records exactly one of four outcomes in sticky status flags. The outcomes are: sent with no reply awaited, reply accepted, reply with a bad CRC, and no reply in time.

The timeout window is 64 periods of the card clock. It is measured in card-clock enable pulses, so a slow or gated card clock stretches it in time but never shortens it. Software clears flags by writing ones into a clear word. A mask word selects which flags drive the single interrupt line. A level output shows that a command is in flight.

The controller has four states. IDLE waits for an issue pulse. SEND waits for transmission to finish. WAIT_RESP counts card-clock enables while it waits for a reply to start. RECV waits for the reply to end. The transitions are:
- IDLE to SEND on an issue pulse.
- SEND to IDLE on end of transmission when no reply is awaited.
- SEND to WAIT_RESP on end of transmission when a reply is awaited.
- WAIT_RESP to RECV on a reply start.
- WAIT_RESP to IDLE on the 64th enable without a reply start.
- RECV to IDLE on reply end.

Top module: `cmd_outcome_tracker`

## Requirements
- R1: After reset, all four flags, the mask, `cmd_active` and `irq` are 0.
- R2: A command issued with `resp_expected`=0 sets flag bit 0 (sent) on the clock edge that samples `cmd_tx_done`. No flag is set before that edge.
- R3: In RECV, a `resp_done` pulse with `resp_crc_fail`=0 sets flag bit 1 (reply ok) on that edge.
- R4: In RECV, a `resp_done` pulse with `resp_crc_fail`=1 sets flag bit 2 (CRC fail), and bit 1 is not set.
- R5: In WAIT_RESP, the 64th `card_clk_en` pulse without a `resp_start` sets flag bit 3 (timeout). After 63 pulses no flag is set and the command is still active.
- R6: The timeout count advances only on cycles where `card_clk_en`=1. Any number of cycles with `card_clk_en` low leaves the count unchanged.
- R7: Each flag stays set until a cycle with `clr_wr`=1 and a 1 in the matching bit of `clr_data`. Clear bits that are 0 leave their flags unchanged.
- R8: When a flag's set condition and its clear write fall in the same cycle, the flag ends up set.
- R9: `cmd_active` is 1 in every state except IDLE. The controller is back in IDLE on the same edge that records an outcome.
- R10: Each command records exactly one outcome. An issue pulse that arrives while a command is in flight is ignored, together with the reply-expected value that comes with it.
- R11: `irq` equals the OR over the four bits of the flags ANDed with the mask. The mask is loaded from `mask_data` on a cycle with `mask_wr`=1.
- R12: A `resp_start` in the same cycle as the 64th enable pulse wins: the controller goes to RECV and no timeout is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_clk_en | input | 1 | One-cycle pulse per card-clock period |
| cmd_issue | input | 1 | Pulse: a command starts |
| resp_expected | input | 1 | Sampled with cmd_issue: a reply is awaited |
| cmd_tx_done | input | 1 | Pulse: the command finished transmitting |
| resp_start | input | 1 | Pulse: a reply start bit was seen |
| resp_done | input | 1 | Pulse: the reply is complete |
| resp_crc_fail | input | 1 | Valid with resp_done: 1 = CRC mismatch, 0 = pass or no CRC |
| clr_wr | input | 1 | Clear-word write strobe |
| clr_data | input | 4 | Write-one-to-clear bits, same order as the flags |
| mask_wr | input | 1 | Mask-word write strobe |
| mask_data | input | 4 | New interrupt mask |
| status_flags | output | 4 | Sticky flags: bit0 sent, bit1 reply ok, bit2 CRC fail, bit3 timeout |
| cmd_active | output | 1 | Controller not in IDLE |
| irq | output | 1 | OR of the masked flags |

## Verification
The hardest case to reach from the ports is the edge of the timeout window. That means exactly 63 against 64 counted enables, and a reply start that lands in the same cycle as the 64th enable. The stimulus drives `card_clk_en` by hand, one pulse at a time, while the command sits in WAIT_RESP. Long stretches with the enable held low show that idle cycles are never counted. A behavioural model in the bench is compared on every clock, through directed sequences and through a long phase of random pulses.

// File: rtl/cmd_outcome_pkg.sv
package cmd_outcome_pkg;

    localparam int NUM_OUTCOMES = 4;

    localparam int OC_SENT    = 0;
    localparam int OC_RESP_OK = 1;
    localparam int OC_CRC_BAD = 2;
    localparam int OC_TIMEOUT = 3;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SEND      = 2'd1,
        ST_WAIT_RESP = 2'd2,
        ST_RECV      = 2'd3
    } cmd_state_e;

endpackage

// File: rtl/cmd_resp_timer.sv
module cmd_resp_timer #(
    parameter int TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(TICKS) + 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expired = tick && !restart && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (expired)        cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end

    // R5: count never passes the window
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6: no enable pulse, no progress
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/cmd_path_fsm.sv
module cmd_path_fsm
    import cmd_outcome_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    card_clk_en,
    input  logic                    cmd_issue,
    input  logic                    resp_expected,
    input  logic                    cmd_tx_done,
    input  logic                    resp_start,
    input  logic                    resp_done,
    input  logic                    resp_crc_fail,
    input  logic                    timer_expired,
    output logic                    timer_restart,
    output logic                    timer_tick,
    output logic [NUM_OUTCOMES-1:0] set_vec,
    output logic                    active
);
    cmd_state_e state_q, state_d;
    logic       want_resp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            want_resp_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_issue)
                want_resp_q <= resp_expected;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cmd_issue) state_d = ST_SEND;
            ST_SEND:      if (cmd_tx_done) state_d = want_resp_q ? ST_WAIT_RESP : ST_IDLE;
            ST_WAIT_RESP: if (resp_start) state_d = ST_RECV;
                          else if (timer_expired) state_d = ST_IDLE;
            ST_RECV:      if (resp_done) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        set_vec       = '0;
        timer_restart = (state_q != ST_WAIT_RESP);
        timer_tick    = (state_q == ST_WAIT_RESP) && card_clk_en && !resp_start;
        active        = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:      ;
            ST_SEND:      if (cmd_tx_done && !want_resp_q) set_vec[OC_SENT] = 1'b1;
            ST_WAIT_RESP: if (!resp_start && timer_expired) set_vec[OC_TIMEOUT] = 1'b1;
            ST_RECV:      if (resp_done) begin
                              if (resp_crc_fail) set_vec[OC_CRC_BAD] = 1'b1;
                              else               set_vec[OC_RESP_OK] = 1'b1;
                          end
            default:      ;
        endcase
    end

    // R10: never two outcomes at once
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    // R9: outcome recorded means idle next
    a_r9_idle_after_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> (state_q == ST_IDLE));

    // R10: a busy wait is not disturbed by new issue pulses
    a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RESP && !resp_start && !timer_expired) |=> (state_q == ST_WAIT_RESP));

    // R12: reply start leads to RECV, never to a timeout
    a_r12_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RESP && resp_start) |=> (state_q == ST_RECV));

endmodule

// File: rtl/outcome_flag_bank.sv
module outcome_flag_bank
    import cmd_outcome_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_OUTCOMES-1:0] set_vec,
    input  logic                    clr_wr,
    input  logic [NUM_OUTCOMES-1:0] clr_data,
    input  logic                    mask_wr,
    input  logic [NUM_OUTCOMES-1:0] mask_data,
    output logic [NUM_OUTCOMES-1:0] flags,
    output logic                    irq
);
    logic [NUM_OUTCOMES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_data;
    end

    for (genvar k = 0; k < NUM_OUTCOMES; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                       flags[k] <= 1'b0;
            else if (set_vec[k])              flags[k] <= 1'b1;
            else if (clr_wr && clr_data[k])   flags[k] <= 1'b0;
        end

        // R8: a set in the same cycle as a clear leaves the flag set
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> flags[k]);

        // R7: sticky unless its own clear bit is written
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[k] && !(clr_wr && clr_data[k])) |=> flags[k]);
    end

    assign irq = |(flags & mask_q);

endmodule

// File: rtl/cmd_outcome_tracker.sv
module cmd_outcome_tracker
    import cmd_outcome_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    card_clk_en,
    input  logic                    cmd_issue,
    input  logic                    resp_expected,
    input  logic                    cmd_tx_done,
    input  logic                    resp_start,
    input  logic                    resp_done,
    input  logic                    resp_crc_fail,
    input  logic                    clr_wr,
    input  logic [NUM_OUTCOMES-1:0] clr_data,
    input  logic                    mask_wr,
    input  logic [NUM_OUTCOMES-1:0] mask_data,
    output logic [NUM_OUTCOMES-1:0] status_flags,
    output logic                    cmd_active,
    output logic                    irq
);
    logic                    tmr_restart;
    logic                    tmr_tick;
    logic                    tmr_expired;
    logic [NUM_OUTCOMES-1:0] outcome_set;

    cmd_path_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_clk_en   (card_clk_en),
        .cmd_issue     (cmd_issue),
        .resp_expected (resp_expected),
        .cmd_tx_done   (cmd_tx_done),
        .resp_start    (resp_start),
        .resp_done     (resp_done),
        .resp_crc_fail (resp_crc_fail),
        .timer_expired (tmr_expired),
        .timer_restart (tmr_restart),
        .timer_tick    (tmr_tick),
        .set_vec       (outcome_set),
        .active        (cmd_active)
    );

    cmd_resp_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (tmr_tick),
        .expired (tmr_expired)
    );

    outcome_flag_bank u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (outcome_set),
        .clr_wr    (clr_wr),
        .clr_data  (clr_data),
        .mask_wr   (mask_wr),
        .mask_data (mask_data),
        .flags     (status_flags),
        .irq       (irq)
    );

    // R9: a flag can only rise while a command was in flight
    a_r9_rise_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_active) |=> ((status_flags & ~$past(status_flags)) == '0));

endmodule

// File: tb/cmd_outcome_tracker_tb_top.sv
module cmd_outcome_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_clk_en = 1'b0;
    logic       cmd_issue = 1'b0;
    logic       resp_expected = 1'b0;
    logic       cmd_tx_done = 1'b0;
    logic       resp_start = 1'b0;
    logic       resp_done = 1'b0;
    logic       resp_crc_fail = 1'b0;
    logic       clr_wr = 1'b0;
    logic [3:0] clr_data = 4'd0;
    logic       mask_wr = 1'b0;
    logic [3:0] mask_data = 4'd0;
    logic [3:0] status_flags;
    logic       cmd_active;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cmd_outcome_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en),
        .cmd_issue(cmd_issue), .resp_expected(resp_expected),
        .cmd_tx_done(cmd_tx_done), .resp_start(resp_start),
        .resp_done(resp_done), .resp_crc_fail(resp_crc_fail),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .mask_wr(mask_wr), .mask_data(mask_data),
        .status_flags(status_flags), .cmd_active(cmd_active), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    // m_phase: 0 idle, 1 transmitting, 2 awaiting reply, 3 receiving
    int       m_phase = 0;
    int       m_ticks = 0;
    bit       m_want  = 0;
    bit [3:0] m_flags = 0;
    bit [3:0] m_mask  = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_ticks = 0; m_want = 0; m_flags = 0; m_mask = 0;
        end else begin
            bit [3:0] s;
            s = 4'd0;
            if (m_phase == 0) begin
                if (cmd_issue) begin m_phase = 1; m_want = resp_expected; end
            end else if (m_phase == 1) begin
                if (cmd_tx_done) begin
                    if (m_want) begin m_phase = 2; m_ticks = 0; end
                    else begin s = 4'b0001; m_phase = 0; end
                end
            end else if (m_phase == 2) begin
                if (resp_start) m_phase = 3;
                else if (card_clk_en) begin
                    m_ticks++;
                    if (m_ticks == 64) begin s = 4'b1000; m_phase = 0; end
                end
            end else begin
                if (resp_done) begin
                    s = resp_crc_fail ? 4'b0100 : 4'b0010;
                    m_phase = 0;
                end
            end
            if (clr_wr) m_flags = m_flags & ~clr_data;
            m_flags = m_flags | s;
            if (mask_wr) m_mask = mask_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (status_flags !== m_flags || cmd_active !== (m_phase != 0) ||
                irq !== |(m_flags & m_mask)) begin
                fails++;
                $display("FAIL R2,R3,R4,R5,R6,R7,R8,R9,R10,R11,R12 model: actual flags=%b act=%b irq=%b expected flags=%b act=%b irq=%b",
                         status_flags, cmd_active, irq, m_flags, m_phase != 0, |(m_flags & m_mask));
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input bit want);
        @(negedge clk); cmd_issue = 1; resp_expected = want;
        @(negedge clk); cmd_issue = 0; resp_expected = 0;
    endtask

    task automatic tx_done();
        @(negedge clk); cmd_tx_done = 1;
        @(negedge clk); cmd_tx_done = 0;
    endtask

    task automatic rstart();
        @(negedge clk); resp_start = 1;
        @(negedge clk); resp_start = 0;
    endtask

    task automatic rdone(input bit bad);
        @(negedge clk); resp_done = 1; resp_crc_fail = bad;
        @(negedge clk); resp_done = 0; resp_crc_fail = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); card_clk_en = 1;
            @(negedge clk); card_clk_en = 0;
        end
    endtask

    task automatic w1c(input logic [3:0] v);
        @(negedge clk); clr_wr = 1; clr_data = v;
        @(negedge clk); clr_wr = 0; clr_data = 0;
    endtask

    task automatic set_mask(input logic [3:0] v);
        @(negedge clk); mask_wr = 1; mask_data = v;
        @(negedge clk); mask_wr = 0; mask_data = 0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        idle(3);
        // R1: reset state
        chk("R1 flags", status_flags, 0);
        chk("R1 active", cmd_active, 0);
        chk("R1 irq", irq, 0);
        @(negedge clk); rst_n = 1;

        // R2: no reply awaited
        issue(0);
        chk("R9 active in SEND", cmd_active, 1);
        idle(3);
        chk("R2 nothing before tx done", status_flags, 0);
        tx_done();
        chk("R2 sent flag", status_flags, 4'b0001);
        chk("R9 idle after outcome", cmd_active, 0);

        // R7: selective write-one-to-clear
        w1c(4'b0010);
        chk("R7 unrelated clear", status_flags, 4'b0001);
        w1c(4'b0001);
        chk("R7 own clear", status_flags, 0);

        // R3: good reply
        issue(1); tx_done();
        chk("R9 active awaiting reply", cmd_active, 1);
        rstart(); rdone(0);
        chk("R3 reply ok", status_flags, 4'b0010);
        chk("R9 idle after reply", cmd_active, 0);

        // R4: bad CRC
        issue(1); tx_done(); rstart(); rdone(1);
        chk("R4 crc fail", status_flags, 4'b0110);
        w1c(4'b0110);

        // R6 and R5: timeout window
        issue(1); tx_done();
        idle(300);
        chk("R6 no timeout without enables", status_flags, 0);
        chk("R6 still active", cmd_active, 1);
        ticks(63);
        chk("R5 no timeout at 63", status_flags, 0);
        chk("R5 active at 63", cmd_active, 1);
        ticks(1);
        chk("R5 timeout at 64", status_flags, 4'b1000);
        chk("R9 idle after timeout", cmd_active, 0);
        w1c(4'b1000);

        // R12: reply start on the 64th enable
        issue(1); tx_done(); ticks(63);
        @(negedge clk); resp_start = 1; card_clk_en = 1;
        @(negedge clk); resp_start = 0; card_clk_en = 0;
        chk("R12 no timeout", status_flags, 0);
        chk("R12 still active", cmd_active, 1);
        rdone(0);
        chk("R12 reply ok", status_flags, 4'b0010);
        w1c(4'b0010);

        // R10: issue while busy ignored
        issue(1); tx_done();
        issue(0); tx_done();
        chk("R10 ignored issue", status_flags, 0);
        chk("R10 still active", cmd_active, 1);
        rstart(); rdone(0);
        chk("R10 single outcome", status_flags, 4'b0010);

        // R8: set beats clear
        issue(0);
        @(negedge clk); cmd_tx_done = 1; clr_wr = 1; clr_data = 4'b0011;
        @(negedge clk); cmd_tx_done = 0; clr_wr = 0; clr_data = 0;
        chk("R8 set wins", status_flags, 4'b0001);

        // R11: interrupt masking
        chk("R11 masked off", irq, 0);
        set_mask(4'b0100);
        chk("R11 other bit masked", irq, 0);
        set_mask(4'b0001);
        chk("R11 unmasked", irq, 1);
        w1c(4'b0001);
        chk("R11 cleared", irq, 0);
        set_mask(4'b1111);

        // random pulses, model compared every clock
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            card_clk_en   = ($urandom_range(0, 3) == 0);
            cmd_issue     = ($urandom_range(0, 15) == 0);
            resp_expected = $urandom_range(0, 1);
            cmd_tx_done   = ($urandom_range(0, 7) == 0);
            resp_start    = ($urandom_range(0, 40) == 0);
            resp_done     = ($urandom_range(0, 5) == 0);
            resp_crc_fail = $urandom_range(0, 1);
            clr_wr        = ($urandom_range(0, 9) == 0);
            clr_data      = 4'($urandom_range(0, 15));
            mask_wr       = ($urandom_range(0, 30) == 0);
            mask_data     = 4'($urandom_range(0, 15));
        end
        @(negedge clk);
        card_clk_en = 0; cmd_issue = 0; cmd_tx_done = 0; resp_start = 0;
        resp_done = 0; clr_wr = 0; mask_wr = 0;
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule